// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer with Fetch/Execute Overlap

This block is a small instruction sequencer that decides when a pending maskable interrupt is taken. It fetches one instruction per cycle from an instruction port. The next opcode is fetched while the current one executes, so two instructions always overlap by one cycle. A global interrupt enable flag is set by an enable instruction and cleared by a disable instruction. The sequencer resolves the timing hazards that this overlap creates in a fixed way.

There are two hazards. The first is the shadow after an enable: the instruction after it must complete before any interrupt. The second is the race when a grant is made in the same cycle that a disable executes. In that race the disable always wins. The pending grant is dropped, and fetch restarts at the instruction that was discarded. So no interrupt can ever be entered with the enable flag already cleared. A return-from-interrupt instruction restores the saved flag and opens the same one-instruction shadow.

Top module: `intack_seq`

## Requirements
- R1: During and straight after reset, `fetch_addr` equals the reset address (0), `gie` is 0, and both `vec_stb` and `retire_stb` are 0.
- R2: The instruction word holds a 3-bit opcode above an 8-bit target field. The opcodes are: NOP=0, enable=1, disable=2, jump=3 (target in the low bits), return=4. Codes 5 to 7 are single-cycle operations with no control effect. Back-to-back non-jump instructions retire on consecutive cycles.
- R3: An enable sets `gie`. The instruction that follows it always retires before any interrupt vector strobe, even when `irq` has been high the whole time.
- R4: Suppose a grant is made in the cycle a disable executes. Then no vector strobe follows, and execution resumes at the instruction after the disable with `gie` at 0.
- R5: An enable directly followed by a disable never produces a vector strobe.
- R6: A grant can occur when `irq` is high, `gie` is 1, no shadow is open, and the executing instruction is not a jump or return. That instruction then retires. One cycle later `vec_stb` pulses, with `gie` at 1 in the cycle before and 0 during the pulse, and fetch moves to the vector address. The first handler instruction retires two cycles after the strobe.
- R7: A jump continues at its target. It costs one bubble, so the next retire comes two cycles after the jump retires.
- R8: A return restores the saved enable. It resumes at the first instruction that was not executed before the dispatch, and that instruction retires before the next dispatch.
- R9: With `irq` held low, no vector strobe ever occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 11 | Instruction word read at `fetch_addr` in the same cycle |
| irq | input | 1 | Maskable interrupt request (level) |
| fetch_addr | output | 8 | Registered fetch address |
| vec_stb | output | 1 | One-cycle pulse when an interrupt is dispatched |
| gie | output | 1 | Current global interrupt enable |
| retire_stb | output | 1 | Pulses once for each retired instruction |
| retire_pc | output | 8 | Address of the instruction retiring |

## Verification
Two events can fall in the same cycle: the grant decision and the execution of a disable. A second collision is between the grant and the shadowed instruction after an enable. Both are provoked by holding `irq` high across short enable/NOP/disable, enable/disable and disable-then-critical sequences, and across random programs. Each run's retire and dispatch order is compared with an instruction-level model that applies the shadow and disable-wins rules. Every dispatch is also checked to have seen `gie` at 1 just before it.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_EINT = 3'd1,
    OP_DINT = 3'd2,
    OP_JMP  = 3'd3,
    OP_RETI = 3'd4,
    OP_AL5  = 3'd5,
    OP_AL6  = 3'd6,
    OP_AL7  = 3'd7
  } op_e;

  function automatic logic op_is_flow(op_e op);
    return (op == OP_JMP) || (op == OP_RETI);
  endfunction
endpackage

// File: rtl/isq_fetch.sv
module isq_fetch
  import isq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W+ADDR_W-1:0] instr_in,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              discard,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              ex_valid,
  output op_e               ex_op,
  output logic [ADDR_W-1:0] ex_tgt,
  output logic [ADDR_W-1:0] ex_pc
);
  logic [ADDR_W-1:0] fa_q, tgt_q, pc_q;
  logic              vld_q;
  op_e               op_q;

  // Prefetch latch: the word fetched this cycle executes in the next one.
  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q  <= ADDR_W'(RESET_ADDR);
      vld_q <= 1'b0;
      op_q  <= OP_NOP;
      tgt_q <= '0;
      pc_q  <= '0;
    end else if (redirect) begin
      fa_q  <= redirect_addr;
      vld_q <= 1'b0;
    end else begin
      fa_q  <= fa_q + 1'b1;
      vld_q <= !discard;
      op_q  <= op_e'(instr_in[OP_W+ADDR_W-1:ADDR_W]);
      tgt_q <= instr_in[ADDR_W-1:0];
      pc_q  <= fa_q;
    end
  end

  assign fetch_addr = fa_q;
  assign ex_valid   = vld_q;
  assign ex_op      = op_q;
  assign ex_tgt     = tgt_q;
  assign ex_pc      = pc_q;
endmodule

// File: rtl/isq_gie.sv
module isq_gie
  import isq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ex_valid,
  input  op_e  ex_op,
  input  logic dispatch,
  output logic gie,
  output logic shadow
);
  logic gie_q, sh_q, saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      sh_q    <= 1'b0;
      saved_q <= 1'b0;
    end else if (dispatch) begin
      saved_q <= gie_q;
      gie_q   <= 1'b0;
      sh_q    <= 1'b0;
    end else if (ex_valid) begin
      unique case (ex_op)
        OP_EINT: begin gie_q <= 1'b1;    sh_q <= 1'b1; end
        OP_DINT: begin gie_q <= 1'b0;    sh_q <= 1'b0; end
        OP_RETI: begin gie_q <= saved_q; sh_q <= 1'b1; end
        default: sh_q <= 1'b0;
      endcase
    end
  end

  assign gie    = gie_q;
  assign shadow = sh_q;
endmodule

// File: rtl/isq_arb.sv
module isq_arb
  import isq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int VEC_ADDR = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              ex_valid,
  input  op_e               ex_op,
  input  logic              gie,
  input  logic              shadow,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              discard,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              dispatch,
  output logic [ADDR_W-1:0] ret_pc
);
  logic              flush_q;
  logic [ADDR_W-1:0] ret_q;
  logic              grant;

  // Grant: the executing instruction retires, its prefetched successor is dropped.
  assign grant = !flush_q && ex_valid && irq && gie && !shadow && !op_is_flow(ex_op);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= 1'b0;
      ret_q   <= '0;
    end else if (grant) begin
      flush_q <= 1'b1;
      ret_q   <= fetch_addr;
    end else begin
      flush_q <= 1'b0;
    end
  end

  // Flush cycle: enter the vector, or cancel and refetch if the flag was cleared.
  assign discard       = grant;
  assign redirect      = flush_q;
  assign dispatch      = flush_q && gie;
  assign redirect_addr = gie ? ADDR_W'(VEC_ADDR) : ret_q;
  assign ret_pc        = ret_q;

  a_r4_disable_wins: assert property (@(posedge clk) disable iff (rst)
    (flush_q && $past(ex_valid && ex_op == OP_DINT)) |-> !dispatch);
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import isq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RESET_ADDR = 0,
  parameter int VEC_ADDR   = 240
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OP_W+ADDR_W-1:0] instr_in,
  input  logic                   irq,
  output logic [ADDR_W-1:0]      fetch_addr,
  output logic                   vec_stb,
  output logic                   gie,
  output logic                   retire_stb,
  output logic [ADDR_W-1:0]      retire_pc
);
  logic              ex_valid, shadow, discard, arb_redir, dispatch, redir;
  op_e               ex_op;
  logic [ADDR_W-1:0] ex_tgt, ex_pc, arb_addr, ret_pc, redir_addr;
  logic              vec_q, ret_stb_q;
  logic [ADDR_W-1:0] ret_pc_q;

  always_comb begin
    redir      = arb_redir;
    redir_addr = arb_addr;
    if (ex_valid && ex_op == OP_JMP) begin
      redir      = 1'b1;
      redir_addr = ex_tgt;
    end else if (ex_valid && ex_op == OP_RETI) begin
      redir      = 1'b1;
      redir_addr = ret_pc;
    end
  end

  isq_fetch #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk, .rst, .instr_in,
    .redirect(redir), .redirect_addr(redir_addr), .discard,
    .fetch_addr, .ex_valid, .ex_op, .ex_tgt, .ex_pc
  );

  isq_gie u_gie (
    .clk, .rst, .ex_valid, .ex_op, .dispatch, .gie, .shadow
  );

  isq_arb #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_arb (
    .clk, .rst, .irq, .ex_valid, .ex_op, .gie, .shadow, .fetch_addr,
    .discard, .redirect(arb_redir), .redirect_addr(arb_addr), .dispatch, .ret_pc
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= 1'b0;
      ret_stb_q <= 1'b0;
      ret_pc_q  <= '0;
    end else begin
      vec_q     <= dispatch;
      ret_stb_q <= ex_valid;
      ret_pc_q  <= ex_pc;
    end
  end

  assign vec_stb    = vec_q;
  assign retire_stb = ret_stb_q;
  assign retire_pc  = ret_pc_q;

  // Checker: instructions executed since the enable flag last became 1 (saturating).
  logic [1:0] en_cnt;
  always_ff @(posedge clk) begin
    if (rst || !gie) en_cnt <= '0;
    else if (ex_valid && en_cnt != 2'd3) en_cnt <= en_cnt + 1'b1;
  end

  a_r3_shadow_retired: assert property (@(posedge clk) disable iff (rst)
    dispatch |-> en_cnt >= 2'd2);
  a_r6_gie_at_dispatch: assert property (@(posedge clk) disable iff (rst)
    vec_stb |-> ($past(gie) && !gie));
  a_r6_vector_fetch: assert property (@(posedge clk) disable iff (rst)
    vec_stb |-> fetch_addr == ADDR_W'(VEC_ADDR));
  a_r6_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    vec_stb |-> !retire_stb);
endmodule

// File: tb/intack_seq_test.sv
`timescale 1ns/1ps
module intack_seq_test;
  localparam int AW  = 8;
  localparam int VEC = 240;
  localparam int MAXEV = 400;

  logic clk = 1'b0, rst = 1'b1, irq = 1'b0;
  logic [10:0] mem [256];
  logic [AW-1:0] fetch_addr, retire_pc;
  logic vec_stb, gie, retire_stb;

  always #2 clk = ~clk;

  intack_seq uut (
    .clk, .rst, .instr_in(mem[fetch_addr]), .irq,
    .fetch_addr, .vec_stb, .gie, .retire_stb, .retire_pc
  );

  int n_chk = 0, n_bad = 0;
  int ev_pc [MAXEV];
  int ev_cy [MAXEV];
  int dlen, cyc, total_cyc;
  int m_ev [MAXEV];
  int mlen;
  bit log_en = 1'b0, gie_prev = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] ins(int op, int tgt);
    return {op[2:0], tgt[7:0]};
  endfunction

  always @(negedge clk) begin
    total_cyc++;
    if (total_cyc > 100000) begin
      chk(1'b0, "watchdog", "cycles", total_cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    if (log_en) begin
      cyc++;
      if (retire_stb && dlen < MAXEV) begin ev_pc[dlen] = int'(retire_pc); ev_cy[dlen] = cyc; dlen++; end
      if (vec_stb) begin
        chk(gie_prev && !gie, "R6", "gie before/at dispatch", {gie_prev, gie}, 2);
        if (dlen < MAXEV) begin ev_pc[dlen] = -1; ev_cy[dlen] = cyc; dlen++; end
      end
      gie_prev = gie;
    end
  end

  // Instruction-level model: shadow after enable/return, disable wins a grant race.
  task automatic model(int need, bit irq_lvl);
    int pc = 0, ret = 0, steps = 0;
    bit g = 0, sh = 0, sv = 0;
    mlen = 0;
    while (mlen < need && steps < 4000) begin
      int op = int'(mem[pc][10:8]);
      int nxt;
      bit grant = irq_lvl && g && !sh && !(op == 3 || op == 4);
      steps++;
      m_ev[mlen++] = pc;
      nxt = (op == 3) ? int'(mem[pc][7:0]) : (op == 4) ? ret : ((pc + 1) & 255);
      case (op)
        1: begin g = 1; sh = 1; end
        2: begin g = 0; sh = 0; end
        4: begin g = sv; sh = 1; end
        default: sh = 0;
      endcase
      if (grant && g) begin
        if (mlen < MAXEV) m_ev[mlen++] = -1;
        sv = 1; g = 0; sh = 0; ret = (pc + 1) & 255; nxt = VEC;
      end
      pc = nxt;
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = ins(0, 0);
    mem[VEC] = ins(0, 0); mem[VEC+1] = ins(5, 0); mem[VEC+2] = ins(4, 0);
  endtask

  task automatic run(bit irq_lvl, int ncyc, string req, bit chk_reset);
    @(negedge clk);
    rst = 1'b1; log_en = 1'b0; irq = irq_lvl;
    repeat (2) @(negedge clk);
    if (chk_reset) begin
      chk(fetch_addr == 0, "R1", "fetch_addr", int'(fetch_addr), 0);
      chk(gie == 0, "R1", "gie", gie, 0);
      chk(vec_stb == 0, "R1", "vec_stb", vec_stb, 0);
      chk(retire_stb == 0, "R1", "retire_stb", retire_stb, 0);
    end
    dlen = 0; cyc = 0; gie_prev = 1'b0;
    rst = 1'b0; log_en = 1'b1;
    repeat (ncyc) @(negedge clk);
    log_en = 1'b0;
    model(dlen, irq_lvl);
    begin
      int bad = -1;
      for (int i = 0; i < dlen; i++) if (bad < 0 && (i >= mlen || ev_pc[i] != m_ev[i])) bad = i;
      if (bad >= 0) chk(1'b0, req, "event order", ev_pc[bad], (bad < mlen) ? m_ev[bad] : -99);
      else chk(dlen > 20, req, "event order length", dlen, 21);
    end
  endtask

  function automatic int find(int pcv);
    for (int i = 0; i < dlen - 1; i++) if (ev_pc[i] == pcv) return i;
    return -1;
  endfunction

  function automatic int count_vec();
    int c = 0;
    for (int i = 0; i < dlen; i++) if (ev_pc[i] == -1) c++;
    return c;
  endfunction

  initial begin
    int i;
    void'($urandom(32'd4711));

    // R5: enable then disable back to back, request always high.
    clear_mem();
    mem[0] = ins(1, 0); mem[1] = ins(2, 0); mem[2] = ins(5, 0); mem[3] = ins(0, 0); mem[4] = ins(3, 2);
    run(1'b1, 120, "R5", 1'b1);
    chk(count_vec() == 0, "R5", "dispatches", count_vec(), 0);
    chk(gie == 0, "R5", "gie after", gie, 0);

    // R4: enable, NOP, disable, critical op: grant races the disable.
    clear_mem();
    mem[0] = ins(1, 0); mem[1] = ins(0, 0); mem[2] = ins(2, 0); mem[3] = ins(6, 0); mem[4] = ins(3, 3);
    run(1'b1, 120, "R4", 1'b0);
    chk(count_vec() == 0, "R4", "dispatches", count_vec(), 0);
    i = find(2);
    chk(i >= 0 && ev_pc[i+1] == 3, "R4", "after disable", (i >= 0) ? ev_pc[i+1] : -2, 3);

    // R3/R6/R8: enable then plain ops, dispatch and return.
    clear_mem();
    mem[0] = ins(1, 0); mem[1] = ins(0, 0); mem[2] = ins(5, 0); mem[3] = ins(0, 0); mem[4] = ins(3, 0);
    run(1'b1, 150, "R3", 1'b0);
    i = find(-1);
    chk(i >= 2 && ev_pc[i-1] == 2 && ev_pc[i-2] == 1, "R3", "shadow op before vector",
        (i >= 1) ? ev_pc[i-1] : -2, 2);
    chk(i >= 1 && ev_cy[i] - ev_cy[i-1] == 1, "R6", "grant retire to strobe",
        (i >= 1) ? ev_cy[i] - ev_cy[i-1] : -2, 1);
    chk(i >= 0 && ev_pc[i+1] == VEC && ev_cy[i+1] - ev_cy[i] == 2, "R6", "strobe to handler",
        (i >= 0) ? ev_cy[i+1] - ev_cy[i] : -2, 2);
    i = find(VEC + 2);
    chk(i >= 0 && ev_pc[i+1] == 3, "R8", "return address", (i >= 0) ? ev_pc[i+1] : -2, 3);

    // R9/R7/R2: request low, with enables and a jump.
    clear_mem();
    mem[0] = ins(1, 0); mem[1] = ins(0, 0); mem[2] = ins(5, 0); mem[3] = ins(3, 0);
    run(1'b0, 120, "R9", 1'b0);
    chk(count_vec() == 0, "R9", "dispatches", count_vec(), 0);
    i = find(1);
    chk(i >= 0 && ev_cy[i+1] - ev_cy[i] == 1, "R2", "overlap gap", (i >= 0) ? ev_cy[i+1] - ev_cy[i] : -2, 1);
    i = find(3);
    chk(i >= 0 && ev_pc[i+1] == 0 && ev_cy[i+1] - ev_cy[i] == 2, "R7", "jump gap",
        (i >= 0) ? ev_cy[i+1] - ev_cy[i] : -2, 2);

    // Random programs mixing enables, disables, jumps; compared against the model (R3 R4 R6 R8).
    for (int r = 0; r < 20; r++) begin
      clear_mem();
      for (int a = 0; a < 16; a++) begin
        int k = int'($urandom % 10);
        if (k < 3) mem[a] = ins(0, 0);
        else if (k < 5) mem[a] = ins(5 + (k % 3), 0);
        else if (k < 7) mem[a] = ins(1, 0);
        else if (k < 9) mem[a] = ins(2, 0);
        else mem[a] = ins(3, int'($urandom % 16));
      end
      mem[16] = ins(3, 0);
      run(($urandom % 4) != 0, 150, "R8", 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule